// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

A single DMA channel that copies a run of items from a source address to a destination address over a 32-bit memory master port. Software loads a source pointer, a destination pointer, a chain pointer and a control word through a small word-indexed register port, then sets the enable bit. After that the channel moves data only when a peripheral raises a request. A single request moves one item. A burst request moves a programmed number of items, but never more than are left in the current run.

Every item is read into a four-word internal FIFO and then written out. When the run count reaches zero, the channel sets its raw count status. If the chain pointer is nonzero, it then fetches the next four-word descriptor from memory and continues. If the chain pointer is zero, it clears its enable bit.

A bus error response aborts the channel and sets the raw error status. Both raw status bits pass through per-source enables to form the masked status and the interrupt line. Byte lanes follow little-endian order.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset, every register reads 0, and `m_req`, `dack` and `irq` are 0.
- R2: While enabled and idle, a `dreq_single` request moves exactly one item (one read, then one write). `dack` pulses for one cycle after the write completes.
- R3: A `dreq_burst` request moves min(burst length, items left) items, then pulses `dack`. Burst code CTRL[13:12] selects the length: 0=1, 1=4, 2=8, 3=16.
- R4: CTRL[16] enables source increment and CTRL[17] enables destination increment. An incrementing address steps by the item size in bytes after each item; a fixed address never changes.
- R5: Item size code CTRL[15:14] selects the width: 0=8, 1=16, 2=32 bits. `m_size` carries the code during data beats. Byte lanes are little-endian: a byte sits at data bits 8*addr[1:0] and a halfword at bits 16*addr[1].
- R6: The FIFO holds four items. At most four reads occur between writes, and an 8-item burst of words runs as four reads, then four writes, twice.
- R7: When the count CTRL[11:0] reaches 0 and the chain register is nonzero, the channel reads the words at chain+0, +4, +8 and +12 into source, destination, chain and control, and stays enabled. With a zero chain register, it clears enable (CONFIG bit 0). Enabling with a count of 0 completes at once, with no data beats.
- R8: RAW status (index 5) bit 0 sets at every count expiry and bit 1 sets on an error response. Writing a 1 to a bit clears it.
- R9: MASKED status (index 6) is RAW ANDed with CONFIG bits {2,1} (error, count). `irq` is the OR of the masked bits.
- R10: An error response aborts the channel: enable clears, no `dack` is given, buffered items are discarded unwritten, and `m_req` stays low.
- R11: Register indices are 0=source, 1=destination, 2=chain, 3=control, 4=config. Writes to indices 0 to 3 are ignored while the channel is enabled or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dreq_single | input | 1 | Single-item request, held until `dack` |
| dreq_burst | input | 1 | Burst request, held until `dack` |
| dack | output | 1 | Request served pulse |
| m_req | output | 1 | Bus beat request |
| m_we | output | 1 | Beat is a write |
| m_addr | output | 32 | Byte address of the beat |
| m_size | output | 2 | Size code of the beat |
| m_wdata | output | 32 | Write data, lane placed |
| m_rdata | input | 32 | Read data |
| m_ready | input | 1 | Beat completes this cycle |
| m_err | input | 1 | Error response, qualified by `m_ready` |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
A table of copy jobs covers several combinations:
- Single requests against burst requests of every length code. This shows the per-request item count apart from the remaining count.
- Word, halfword and byte sizes at unaligned offsets. This separates the lane placement and step size.
- Fixed source or fixed destination. This proves the increment enables work independently.

Each job is compared word for word with a reference copy. The bus model stalls on a periodic pattern, so address hold is exercised. Directed cases cover:
- A two-descriptor chain.
- A zero-count start.
- An error injected on a mid-burst read.
- Writes attempted while the channel is enabled.
- The mask and write-one-to-clear behaviour of the status bits.

// File: rtl/dmac_pkg.sv
// Shared constants and types for the chained-descriptor DMA channel.
// Assumes control-word field positions are fixed; the count field is 12 bits.
package dmac_pkg;
    localparam int CNT_W     = 12;
    localparam int BCODE_LSB = 12;
    localparam int WCODE_LSB = 14;
    localparam int SINC_BIT  = 16;
    localparam int DINC_BIT  = 17;

    localparam logic [2:0] REG_SRC = 3'd0;
    localparam logic [2:0] REG_DST = 3'd1;
    localparam logic [2:0] REG_NXT = 3'd2;
    localparam logic [2:0] REG_CTL = 3'd3;
    localparam logic [2:0] REG_CFG = 3'd4;
    localparam logic [2:0] REG_RAW = 3'd5;
    localparam logic [2:0] REG_MSK = 3'd6;

    localparam logic [1:0] W_BYTE = 2'd0;
    localparam logic [1:0] W_HALF = 2'd1;
    localparam logic [1:0] W_WORD = 2'd2;

    typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_ACK, S_DONE, S_LL} state_t;

    // Items moved per burst request for a burst code.
    function automatic logic [4:0] burst_len(input logic [1:0] code);
        case (code)
            2'd0:    burst_len = 5'd1;
            2'd1:    burst_len = 5'd4;
            2'd2:    burst_len = 5'd8;
            default: burst_len = 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/dmac_fifo.sv
// Small item buffer between the read and write phases of the channel.
// Assumes the controller never pushes when full nor pops when empty.
module dmac_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  pdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;

    // Pointer and occupancy update, flush has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            count <= '0;
        end else begin
            if (push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem_q[wp_q] <= pdata;
    end

    assign head  = mem_q[rp_q];
    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dmac_lane.sv
// Little-endian lane steering and address step for one item size.
// Assumes size code 3 is treated as a word.
module dmac_lane
    import dmac_pkg::*;
(
    input  logic [1:0]  wcode,
    input  logic [1:0]  rd_off,
    input  logic [31:0] rdata,
    input  logic [1:0]  wr_off,
    input  logic [31:0] item,
    output logic [31:0] item_out,
    output logic [31:0] wdata,
    output logic [2:0]  step
);
    // Extract the read item and place the write item on their lanes.
    always_comb begin
        case (wcode)
            W_BYTE: begin
                item_out = {24'b0, rdata[{rd_off, 3'b000} +: 8]};
                wdata    = {24'b0, item[7:0]} << {wr_off, 3'b000};
                step     = 3'd1;
            end
            W_HALF: begin
                item_out = {16'b0, rdata[{rd_off[1], 4'b0000} +: 16]};
                wdata    = {16'b0, item[15:0]} << {wr_off[1], 4'b0000};
                step     = 3'd2;
            end
            default: begin
                item_out = rdata;
                wdata    = item;
                step     = 3'd4;
            end
        endcase
    end
endmodule

// File: rtl/dma_chain_channel.sv
// One DMA channel: request-driven copy through a FIFO, descriptor chaining,
// raw/masked count and error status. Assumes one outstanding bus beat,
// completed by m_ready, with m_err valid only with m_ready.
module dma_chain_channel
    import dmac_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        dreq_single,
    input  logic        dreq_burst,
    output logic        dack,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [1:0]  m_size,
    output logic [31:0] m_wdata,
    input  logic [31:0] m_rdata,
    input  logic        m_ready,
    input  logic        m_err,
    output logic        irq
);
    state_t      state_q;
    logic [31:0] src_q, dst_q, nxt_q, ctl_q, ll_base_q;
    logic        en_q, tcie_q, erie_q, raw_tc_q, raw_er_q;
    logic [4:0]  grant_q;
    logic [1:0]  ll_idx_q;

    logic [CNT_W-1:0] cnt;
    logic [1:0]  wcode, bcode;
    logic        sinc, dinc, ok, bad, busy, push, pop, flush;
    logic [4:0]  blen;
    logic [2:0]  step;
    logic [31:0] item_in, fifo_head;
    logic [CW-1:0] fifo_count;
    logic        fifo_full, fifo_empty;
    logic [1:0]  masked;

    assign cnt   = ctl_q[CNT_W-1:0];
    assign bcode = ctl_q[BCODE_LSB +: 2];
    assign wcode = ctl_q[WCODE_LSB +: 2];
    assign sinc  = ctl_q[SINC_BIT];
    assign dinc  = ctl_q[DINC_BIT];
    assign blen  = burst_len(bcode);
    assign ok    = m_req && m_ready && !m_err;
    assign bad   = m_req && m_ready && m_err;
    assign busy  = en_q || (state_q != S_IDLE);
    assign push  = (state_q == S_RD) && ok;
    assign pop   = (state_q == S_WR) && ok;
    assign flush = bad;

    dmac_lane i_lane (
        .wcode(wcode), .rd_off(src_q[1:0]), .rdata(m_rdata),
        .wr_off(dst_q[1:0]), .item(fifo_head),
        .item_out(item_in), .wdata(m_wdata), .step(step)
    );

    dmac_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) i_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pdata(item_in),
        .pop(pop), .head(fifo_head), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty)
    );

    // Bus beat drive from the current state.
    always_comb begin
        m_req  = (state_q == S_RD) || (state_q == S_WR) || (state_q == S_LL);
        m_we   = (state_q == S_WR);
        m_size = (state_q == S_LL) ? W_WORD : wcode;
        case (state_q)
            S_WR:    m_addr = dst_q;
            S_LL:    m_addr = ll_base_q + {28'b0, ll_idx_q, 2'b00};
            default: m_addr = src_q;
        endcase
    end

    assign dack   = (state_q == S_ACK);
    assign masked = {raw_er_q & erie_q, raw_tc_q & tcie_q};
    assign irq    = |masked;

    // Register read mux.
    always_comb begin
        case (cfg_addr)
            REG_SRC: cfg_rdata = src_q;
            REG_DST: cfg_rdata = dst_q;
            REG_NXT: cfg_rdata = nxt_q;
            REG_CTL: cfg_rdata = ctl_q;
            REG_CFG: cfg_rdata = {29'b0, erie_q, tcie_q, en_q};
            REG_RAW: cfg_rdata = {30'b0, raw_er_q, raw_tc_q};
            REG_MSK: cfg_rdata = {30'b0, masked};
            default: cfg_rdata = '0;
        endcase
    end

    // Register writes, then the channel sequencer (later updates win).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            {src_q, dst_q, nxt_q, ctl_q, ll_base_q} <= '0;
            {en_q, tcie_q, erie_q, raw_tc_q, raw_er_q} <= '0;
            grant_q  <= '0;
            ll_idx_q <= '0;
        end else begin
            if (cfg_we) begin
                case (cfg_addr)
                    REG_SRC: if (!busy) src_q <= cfg_wdata;
                    REG_DST: if (!busy) dst_q <= cfg_wdata;
                    REG_NXT: if (!busy) nxt_q <= cfg_wdata;
                    REG_CTL: if (!busy) ctl_q <= cfg_wdata;
                    REG_CFG: {erie_q, tcie_q, en_q} <= cfg_wdata[2:0];
                    REG_RAW: begin
                        if (cfg_wdata[0]) raw_tc_q <= 1'b0;
                        if (cfg_wdata[1]) raw_er_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            case (state_q)
                S_IDLE: if (en_q) begin
                    if (cnt == '0) state_q <= S_DONE;
                    else if (dreq_burst) begin
                        grant_q <= (cnt < CNT_W'(blen)) ? cnt[4:0] : blen;
                        state_q <= S_RD;
                    end else if (dreq_single) begin
                        grant_q <= 5'd1;
                        state_q <= S_RD;
                    end
                end
                S_RD: if (ok) begin
                    if (sinc) src_q <= src_q + {29'b0, step};
                    ctl_q[CNT_W-1:0] <= cnt - 1'b1;
                    grant_q <= grant_q - 1'b1;
                    if (grant_q == 5'd1 || fifo_count == CW'(FIFO_DEPTH - 1))
                        state_q <= S_WR;
                end
                S_WR: if (ok) begin
                    if (dinc) dst_q <= dst_q + {29'b0, step};
                    if (fifo_count == CW'(1))
                        state_q <= (grant_q == '0) ? S_ACK : S_RD;
                end
                S_ACK: state_q <= (cnt == '0) ? S_DONE : S_IDLE;
                S_DONE: begin
                    raw_tc_q <= 1'b1;
                    if (nxt_q != '0) begin
                        ll_base_q <= nxt_q;
                        ll_idx_q  <= '0;
                        state_q   <= S_LL;
                    end else begin
                        en_q    <= 1'b0;
                        state_q <= S_IDLE;
                    end
                end
                S_LL: if (ok) begin
                    case (ll_idx_q)
                        2'd0:    src_q <= m_rdata;
                        2'd1:    dst_q <= m_rdata;
                        2'd2:    nxt_q <= m_rdata;
                        default: ctl_q <= m_rdata;
                    endcase
                    ll_idx_q <= ll_idx_q + 1'b1;
                    if (ll_idx_q == 2'd3) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
            if (bad) begin
                en_q     <= 1'b0;
                raw_er_q <= 1'b1;
                state_q  <= S_IDLE;
            end
        end
    end

    p_err_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (!en_q && raw_er_q && !m_req));
    p_wr_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> !fifo_empty);
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> ($stable(m_addr) && m_req));
    p_dack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> !dack);
    p_fifo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !push);
endmodule

// File: tb/test_dma_chain_channel.sv
module test_dma_chain_channel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dreq_single = 1'b0, dreq_burst = 1'b0, dack;
    logic        m_req, m_we, m_ready, m_err, irq;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [1:0]  m_size;

    logic [31:0] mem [256];
    logic [31:0] ref_mem [256];
    int  cyc = 0, nchk = 0, nerr = 0;
    int  run = 0, run_max = 0, size_bad = 0, req_seen = 0;
    bit  err_on = 0, sz_chk = 0;
    logic [9:0] err_addr = '0;
    logic [1:0] exp_w = '0;
    logic stall;

    assign stall   = (cyc % 3 == 2);
    assign m_ready = m_req && !stall;
    assign m_rdata = mem[m_addr[9:2]];
    assign m_err   = err_on && m_req && (m_addr[9:0] == err_addr);

    dma_chain_channel i_dma_chain_channel (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq_single(dreq_single),
        .dreq_burst(dreq_burst), .dack(dack), .m_req(m_req), .m_we(m_we),
        .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ready(m_ready), .m_err(m_err), .irq(irq)
    );

    // Bus memory model and monitors, evaluated away from the active edge.
    always @(negedge clk) begin
        if (m_req) req_seen++;
        if (m_req && m_ready && !m_err) begin
            if (m_we) begin
                run = 0;
                case (m_size)
                    2'd0: mem[m_addr[9:2]][{m_addr[1:0], 3'b000} +: 8] = m_wdata[{m_addr[1:0], 3'b000} +: 8];
                    2'd1: mem[m_addr[9:2]][{m_addr[1], 4'b0000} +: 16] = m_wdata[{m_addr[1], 4'b0000} +: 16];
                    default: mem[m_addr[9:2]] = m_wdata;
                endcase
            end else begin
                run++;
                if (run > run_max) run_max = run;
            end
            if (sz_chk && m_size != exp_w) size_bad++;
        end
        cyc++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic request(input bit burst, output bit got);
        got = 0;
        @(negedge clk);
        if (burst) dreq_burst = 1'b1; else dreq_single = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (dack) begin got = 1; break; end
        end
        dreq_burst = 1'b0; dreq_single = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] ref_get(input logic [9:0] a, input logic [1:0] w);
        case (w)
            2'd0: ref_get = {24'b0, ref_mem[a[9:2]][{a[1:0], 3'b000} +: 8]};
            2'd1: ref_get = {16'b0, ref_mem[a[9:2]][{a[1], 4'b0000} +: 16]};
            default: ref_get = ref_mem[a[9:2]];
        endcase
    endfunction

    task automatic ref_move(input logic [9:0] s, input logic [9:0] d, input int n,
                            input logic [1:0] w, input bit si, input bit di);
        int st;
        logic [31:0] it;
        logic [9:0] sa, da;
        st = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        for (int k = 0; k < n; k++) begin
            sa = si ? s + 10'(k * st) : s;
            da = di ? d + 10'(k * st) : d;
            it = ref_get(sa, w);
            case (w)
                2'd0: ref_mem[da[9:2]][{da[1:0], 3'b000} +: 8] = it[7:0];
                2'd1: ref_mem[da[9:2]][{da[1], 4'b0000} +: 16] = it[15:0];
                default: ref_mem[da[9:2]] = it;
            endcase
        end
    endtask

    function automatic int mem_diff();
        int n = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) n++;
        return n;
    endfunction

    function automatic logic [31:0] ctl(input int n, input logic [1:0] b, input logic [1:0] w,
                                        input bit si, input bit di);
        return {14'b0, di, si, w, b, 12'(n)};
    endfunction

    typedef struct packed {
        logic       burst;
        logic [1:0] bcode;
        logic [1:0] wcode;
        logic       sinc;
        logic       dinc;
        logic [7:0] cnt;
        logic [9:0] src;
        logic [9:0] dst;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 2'd0, 2'd2, 1'b1, 1'b1, 8'd3, 10'h000, 10'h200},
        '{1'b1, 2'd1, 2'd2, 1'b1, 1'b1, 8'd6, 10'h040, 10'h240},
        '{1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 8'd8, 10'h080, 10'h280},
        '{1'b1, 2'd1, 2'd0, 1'b1, 1'b1, 8'd7, 10'h0C1, 10'h2C2},
        '{1'b0, 2'd0, 2'd1, 1'b1, 1'b0, 8'd3, 10'h102, 10'h302},
        '{1'b1, 2'd3, 2'd1, 1'b0, 1'b1, 8'd5, 10'h140, 10'h340},
        '{1'b1, 2'd0, 2'd0, 1'b1, 1'b1, 8'd2, 10'h181, 10'h383}
    };

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        bit got;
        int nreq, exp_req, gl;
        for (int i = 0; i < 256; i++) begin
            mem[i] = {i[7:0] ^ 8'h5a, i[7:0] + 8'd17, ~i[7:0], i[7:0]};
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), d);
            check("R1 register after reset", d, 0);
        end
        check("R1 m_req/dack/irq after reset", {29'b0, m_req, dack, irq}, 0);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9
        foreach (VECS[v]) begin
            ref_move(VECS[v].src, VECS[v].dst, VECS[v].cnt, VECS[v].wcode,
                     VECS[v].sinc, VECS[v].dinc);
            wr(3'd0, {22'b0, VECS[v].src});
            wr(3'd1, {22'b0, VECS[v].dst});
            wr(3'd2, 0);
            wr(3'd3, ctl(VECS[v].cnt, VECS[v].bcode, VECS[v].wcode, VECS[v].sinc, VECS[v].dinc));
            exp_w = VECS[v].wcode; sz_chk = 1; size_bad = 0; run_max = 0;
            wr(3'd4, 32'd1);
            nreq = 0;
            for (int g = 0; g < 40; g++) begin
                rd(3'd4, d);
                if (!d[0]) break;
                request(VECS[v].burst, got);
                nreq++;
            end
            sz_chk = 0;
            gl = VECS[v].burst ? ((VECS[v].bcode == 0) ? 1 : (VECS[v].bcode == 1) ? 4 :
                                  (VECS[v].bcode == 2) ? 8 : 16) : 1;
            exp_req = (VECS[v].cnt + gl - 1) / gl;
            check(VECS[v].burst ? "R3 requests per job" : "R2 requests per job", nreq, exp_req);
            check("R4 R5 destination memory mismatches", mem_diff(), 0);
            check("R5 m_size during data beats", size_bad, 0);
            if (v == 2) check("R6 max reads between writes", run_max, 4);
            rd(3'd4, d);
            check("R7 enable cleared at end of unchained run", d[0], 0);
            rd(3'd5, d);
            check("R8 raw count status set", d, 1);
            rd(3'd6, d);
            check("R9 masked with enable off", {d[1:0], irq}, 0);
            wr(3'd4, 32'd2);
            rd(3'd6, d);
            check("R9 masked count with enable on", {d[1:0], irq}, 3'b011);
            wr(3'd5, 32'd1);
            rd(3'd5, d);
            check("R8 raw cleared by write-one", {d[1:0], irq}, 0);
            wr(3'd4, 32'd0);
        end
        check("R6 reads between writes never above four", run_max <= 4, 1);

        // R7: two-descriptor chain
        mem[248] = 32'h1C0; mem[249] = 32'h3A0; mem[250] = 0; mem[251] = ctl(4, 1, 2, 1, 1);
        for (int i = 248; i < 252; i++) ref_mem[i] = mem[i];
        ref_move(10'h1A0, 10'h380, 2, 2'd2, 1, 1);
        ref_move(10'h1C0, 10'h3A0, 4, 2'd2, 1, 1);
        wr(3'd0, 32'h1A0); wr(3'd1, 32'h380); wr(3'd2, 32'h3E0); wr(3'd3, ctl(2, 1, 2, 1, 1));
        wr(3'd4, 32'd1);
        request(1, got);
        repeat (20) @(negedge clk);
        rd(3'd0, d); check("R7 chained source loaded", d, 32'h1C0);
        rd(3'd1, d); check("R7 chained destination loaded", d, 32'h3A0);
        rd(3'd3, d); check("R7 chained control loaded", d, ctl(4, 1, 2, 1, 1));
        rd(3'd4, d); check("R7 enable kept while chaining", d[0], 1);
        rd(3'd5, d); check("R8 raw count after first descriptor", d, 1);
        wr(3'd5, 32'd1);
        request(1, got);
        repeat (4) @(negedge clk);
        check("R7 chained memory mismatches", mem_diff(), 0);
        rd(3'd4, d); check("R7 enable cleared at chain end", d[0], 0);
        rd(3'd5, d); check("R8 raw count after chain end", d, 1);
        wr(3'd5, 32'd1);

        // R7: zero count completes at once
        wr(3'd3, 0); wr(3'd2, 0);
        req_seen = 0;
        wr(3'd4, 32'd1);
        repeat (4) @(negedge clk);
        rd(3'd4, d); check("R7 zero count clears enable", d[0], 0);
        rd(3'd5, d); check("R8 zero count sets raw count", d, 1);
        check("R7 zero count makes no bus beat", req_seen, 0);
        wr(3'd5, 32'd1);

        // R11: writes ignored while enabled
        wr(3'd0, 32'h10); wr(3'd3, ctl(5, 1, 2, 1, 1));
        wr(3'd4, 32'd1);
        wr(3'd0, 32'hABC); wr(3'd3, 32'h7);
        rd(3'd0, d); check("R11 source write ignored while enabled", d, 32'h10);
        rd(3'd3, d); check("R11 control write ignored while enabled", d, ctl(5, 1, 2, 1, 1));
        wr(3'd4, 32'd0);
        wr(3'd0, 32'h14);
        rd(3'd0, d); check("R11 source write accepted when idle", d, 32'h14);

        // R10: error response on the third read of a burst
        wr(3'd0, 32'h010); wr(3'd1, 32'h210); wr(3'd2, 0); wr(3'd3, ctl(4, 1, 2, 1, 1));
        err_addr = 10'h018; err_on = 1;
        wr(3'd4, 32'd5);
        request(1, got);
        check("R10 no dack after error", got, 0);
        rd(3'd4, d); check("R10 enable cleared by error", d[0], 0);
        rd(3'd5, d); check("R8 raw error set", d, 2);
        rd(3'd6, d); check("R9 masked error and irq", {d[1:0], irq}, 3'b101);
        check("R10 buffered items not written", mem_diff(), 0);
        req_seen = 0;
        repeat (20) @(negedge clk);
        check("R10 no bus beats after abort", req_seen, 0);
        err_on = 0;
        wr(3'd5, 32'd2);
        rd(3'd5, d); check("R8 raw error cleared by write-one", {d[1:0], irq}, 0);

        finish_run();
    end
endmodule